// File: doc/BRIEF.md
# Phase-Command I2C Master

This block is an I2C bus master that software steers one bus phase at a time. A register write selects a phase (start condition, byte transmit, byte receive, byte receive ending in a not-acknowledge, or stop condition) and raises a trigger bit. The engine then clocks the bus and lowers the trigger when the phase is over. Software polls the trigger to learn when the next command may be issued. A transmit or receive phase carries a page of one to eight bytes, which is staged in, or returned through, two 32-bit data words. A transmit phase also reports, per byte, whether the slave acknowledged it.

The SCL half-period is set by a divider field. The pads are open-drain by default and can be switched to push-pull. Optional clock stretching lets a slave hold SCL low, and the engine waits until SCL is seen high again. A whole transfer is built from a sequence such as START, WRITE (address), WRITE or READ pages, and STOP.

Top module: `i2c_phase_master`

## Requirements
- R1: After reset the trigger bit reads 0, both pads are released, and the control word at 0x40 reads 0x0063000C when both lines idle high.
- R2: An accepted trigger reads 1 from the cycle after the command write. It stays 1 for exactly S*(divider+1) clocks and then clears. S is 4 for START, 3 for STOP and 18*N+1 for a data phase of N bytes (stretching off).
- R3: START pulls SCL low, releases SCL, pulls SDA low while SCL is high, then pulls SCL low. Each step lasts one half-period.
- R4: STOP pulls SCL and SDA low, releases SCL, then releases SDA while SCL is high.
- R5: WRITE (command code 2) sends byte i from data bits [8i+7:8i] of the 64-bit pair {word 0x54, word 0x50}, MSB first. It releases SDA for the acknowledge bit. SDA only changes while SCL is low.
- R6: After WRITE, bit 16+i of word 0x44 is 1 when byte i was acknowledged (SDA low). Bits for bytes beyond the page read 0.
- R7: READ (code 5) and READ_LAST (code 4) place received bytes MSB first into the same byte slots, leaving the other slots unchanged. READ acknowledges every byte. READ_LAST leaves the final byte unacknowledged.
- R8: Word 0x44 holds the command in bits 6:4, the page length minus one in bits 10:8 and the trigger in bit 0. A trigger with a code outside 1..5, or with the enable bit clear, is ignored: the trigger reads 0 and the pads do not move.
- R9: While the trigger is high, writes to 0x44, 0x50 and 0x54 are ignored.
- R10: With stretching on, the engine does not advance while it has released SCL but senses it low, and finishes once SCL rises.
- R11: Word 0x40 holds push-pull select in bit 31, the divider in bits 26:16, enable in bit 1 and stretch enable in bit 0. Bits 3 and 2 read the synchronised SCL and SDA levels.
- R12: With bit 31 set, SCL and SDA are actively driven and an idle bus drives both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Read data (combinational) |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_o | output | 1 | SCL output value |
| scl_oe | output | 1 | SCL output enable |
| sda_o | output | 1 | SDA output value |
| sda_oe | output | 1 | SDA output enable |

## Verification
The trigger rises in the clock after the command write is captured and falls exactly S*(divider+1) clocks later. The pad enables follow the internal step one clock behind, so a given step shows at the pads from clock 2+k*(divider+1) after the write. The bench rebuilds this timing from the requirements and compares the trigger and both pad enables at every falling edge during each phase. Received bits are sampled through a two-stage synchroniser near the end of each high half, so the bench's slave follows the same per-step schedule, and acknowledge bits and data words are read back once the trigger has cleared.

// File: rtl/i2c_phase_master.sv
`timescale 1ns/1ps
module i2c_phase_master #(
  parameter int DIV_W   = 11,
  parameter int DIV_RST = 99,
  parameter int MAXB    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [7:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        scl_o,
  output logic        scl_oe,
  output logic        sda_o,
  output logic        sda_oe
);
  localparam int SW = $clog2(18*MAXB + 2);
  localparam int BW = $clog2(MAXB);
  localparam int DW = 8*MAXB;
  localparam logic [7:0] A_CFG = 8'h40, A_CMD = 8'h44, A_D0 = 8'h50, A_D1 = 8'h54;
  localparam logic [2:0] C_START = 3'd1, C_WRITE = 3'd2, C_STOP = 3'd3,
                         C_RLAST = 3'd4, C_READ = 3'd5;

  logic             pp, en, str, busy;
  logic [DIV_W-1:0] div, tmr;
  logic [2:0]       cmd, plen;
  logic [7:0]       ack;
  logic [DW-1:0]    dat;
  logic [1:0]       scl_s, sda_s;
  logic [SW-1:0]    step, last_step;
  logic             scl_lo_q, sda_lo_q, lis_q;
  logic             nxt_scl, nxt_sda, nxt_lis;

  wire is_data = (cmd == C_WRITE) || (cmd == C_RLAST) || (cmd == C_READ);
  wire is_wr   = (cmd == C_WRITE);
  wire valid   = (wr_data[6:4] >= C_START) && (wr_data[6:4] <= C_READ);
  wire start   = wr_en && (wr_addr == A_CMD) && !busy && wr_data[0] && en && valid;

  logic [SW-2:0] bit_i;
  logic [BW-1:0] byte_i;
  logic [3:0]    kb;
  logic [5:0]    bpos;
  assign bit_i  = step[SW-1:1];
  assign byte_i = BW'(bit_i / 9);
  assign kb     = 4'(bit_i % 9);
  assign bpos   = {byte_i, 3'b000} + 6'(3'd7 - kb[2:0]);

  always_comb begin
    case (cmd)
      C_START: last_step = SW'(3);
      C_STOP:  last_step = SW'(2);
      default: last_step = SW'(18 * ({1'b0, plen} + 4'd1));
    endcase
  end

  always_comb begin
    nxt_scl = 1'b0;
    nxt_sda = 1'b0;
    nxt_lis = 1'b0;
    if (cmd == C_START) begin
      nxt_scl = (step == 0) || (step == 3);
      nxt_sda = (step >= 2);
    end else if (cmd == C_STOP) begin
      nxt_scl = (step == 0);
      nxt_sda = (step != 2);
    end else if (is_data && step == last_step) begin
      nxt_scl = 1'b1;
    end else if (is_data) begin
      nxt_scl = !step[0];
      if (kb < 4'd8) begin
        if (is_wr) nxt_sda = !dat[bpos];
        else       nxt_lis = 1'b1;
      end else begin
        if (is_wr) nxt_lis = 1'b1;
        else       nxt_sda = !((cmd == C_RLAST) && (3'(byte_i) == plen));
      end
    end
  end

  wire hold = busy && str && !nxt_scl && !scl_s[1];
  wire tick = (tmr == div);
  wire smp  = tick && is_data && step[0] && (step != last_step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pp <= 1'b0; en <= 1'b0; str <= 1'b0; busy <= 1'b0;
      div <= DIV_W'(DIV_RST); tmr <= '0; cmd <= '0; plen <= '0;
      ack <= '0; dat <= '0; step <= '0;
      scl_s <= 2'b11; sda_s <= 2'b11;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      if (busy && !hold) begin
        if (tick) begin
          tmr  <= '0;
          step <= step + 1'b1;
          if (step == last_step) busy <= 1'b0;
          if (smp) begin
            if (is_wr && kb == 4'd8)      ack[byte_i] <= !sda_s[1];
            else if (!is_wr && kb < 4'd8) dat[bpos]   <= sda_s[1];
          end
        end else begin
          tmr <= tmr + 1'b1;
        end
      end
      if (wr_en) begin
        case (wr_addr)
          A_CFG: begin
            pp  <= wr_data[31];
            div <= wr_data[16 +: DIV_W];
            en  <= wr_data[1];
            str <= wr_data[0];
            if (!wr_data[1]) busy <= 1'b0;
          end
          A_CMD: if (!busy) begin
            cmd  <= wr_data[6:4];
            plen <= wr_data[10:8];
            if (start) begin
              busy <= 1'b1;
              step <= '0;
              tmr  <= '0;
              if (wr_data[6:4] == C_WRITE) ack <= '0;
            end
          end
          A_D0: if (!busy) dat[31:0]  <= wr_data;
          A_D1: if (!busy) dat[63:32] <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_lo_q <= 1'b0; sda_lo_q <= 1'b0; lis_q <= 1'b0;
    end else if (!en) begin
      scl_lo_q <= 1'b0; sda_lo_q <= 1'b0; lis_q <= 1'b0;
    end else if (busy) begin
      scl_lo_q <= nxt_scl; sda_lo_q <= nxt_sda; lis_q <= nxt_lis;
    end
  end

  assign scl_o  = pp ? !scl_lo_q : 1'b0;
  assign scl_oe = pp ? en : scl_lo_q;
  assign sda_o  = pp ? !sda_lo_q : 1'b0;
  assign sda_oe = pp ? (en && !lis_q) : sda_lo_q;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CFG: begin
        rd_data[31]            = pp;
        rd_data[16 +: DIV_W]   = div;
        rd_data[3:0]           = {scl_s[1], sda_s[1], en, str};
      end
      A_CMD: rd_data = {8'h00, ack, 5'b0, plen, 1'b0, cmd, 3'b0, busy};
      A_D0:  rd_data = dat[31:0];
      A_D1:  rd_data = dat[63:32];
      default: ;
    endcase
  end
endmodule

// File: rtl/i2c_phase_master_chk.sv
`timescale 1ns/1ps
module i2c_phase_master_chk #(parameter int SW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          en,
  input logic          start,
  input logic          is_data,
  input logic          scl_lo_q,
  input logic          sda_lo_q,
  input logic [7:0]    ack,
  input logic [SW-1:0] step,
  input logic [SW-1:0] last_step
);
  assert_busy_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> en);
  assert_step_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (step <= last_step));
  assert_ack_held_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(ack));
  assert_sda_moves_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_data && !$stable(sda_lo_q)) |-> scl_lo_q);
endmodule

bind i2c_phase_master i2c_phase_master_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .en(en), .start(start),
  .is_data(is_data), .scl_lo_q(scl_lo_q), .sda_lo_q(sda_lo_q),
  .ack(ack), .step(step), .last_step(last_step)
);

// File: tb/tb_i2c_phase_master.sv
`timescale 1ns/1ps
module tb_i2c_phase_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0, rd_addr = 8'h44;
  logic [31:0] wr_data = '0, rd_data, rv;
  logic scl_o, scl_oe, sda_o, sda_oe, scl_i, sda_i;
  logic slave_low = 1'b0, stretch_low = 1'b0;
  int n_cmp = 0, n_bad = 0, H = 4;
  bit done = 0;
  logic pscl = 1'b0, psda = 1'b0;
  logic [63:0] cur_dat = '0;

  always #2.5 clk = !clk;

  assign scl_i = (scl_oe ? scl_o : 1'b1) && !stretch_low;
  assign sda_i = (sda_oe ? sda_o : 1'b1) && !slave_low;

  i2c_phase_master dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_o), .scl_oe(scl_oe), .sda_o(sda_o), .sda_oe(sda_oe));

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    rd_addr = a; #1; v = rd_data; rd_addr = 8'h44;
  endtask

  function automatic logic [1:0] m_exp(int cmd, int n, int s, logic [63:0] tx);
    int b, i, k;
    logic sc, sd;
    sc = 1'b0; sd = 1'b0;
    if (cmd == 1) begin sc = (s == 0 || s == 3); sd = (s >= 2); end
    else if (cmd == 3) begin sc = (s == 0); sd = (s != 2); end
    else if (s >= 18*n) sc = 1'b1;
    else begin
      b = s/2; i = b/9; k = b%9;
      sc = (s % 2 == 0);
      if (k < 8) sd = (cmd == 2) ? !tx[i*8+7-k] : 1'b0;
      else       sd = (cmd == 2) ? 1'b0 : !(cmd == 4 && i == n-1);
    end
    return {sc, sd};
  endfunction

  function automatic logic s_exp(int cmd, int n, int s, logic [7:0] ap, logic [63:0] rx);
    int b, i, k;
    if (cmd == 1 || cmd == 3 || s >= 18*n) return 1'b0;
    b = s/2; i = b/9; k = b%9;
    if (cmd == 2) return (k == 8) ? ap[i] : 1'b0;
    return (k < 8) ? !rx[i*8+7-k] : 1'b0;
  endfunction

  task automatic run_phase(int cmd, int n, logic [7:0] ap, logic [63:0] rx, bit poke);
    int ns, s;
    string tag;
    logic [1:0] e;
    logic [63:0] tx;
    tx = cur_dat;
    ns = (cmd == 1) ? 4 : (cmd == 3) ? 3 : 18*n+1;
    tag = (cmd == 1) ? "R3" : (cmd == 3) ? "R4" : (cmd == 2) ? "R5" : "R7";
    e = {pscl, psda};
    @(negedge clk); #1;
    rd_addr = 8'h44; wr_en = 1'b1; wr_addr = 8'h44;
    wr_data = 32'(((n-1) << 8) | (cmd << 4) | 1);
    for (int j = 1; j <= ns*H+2; j++) begin
      @(negedge clk); #1;
      if (j == 1) wr_en = 1'b0;
      chk("R2 trigger", 32'(rd_data[0]), 32'(j <= ns*H));
      if (j >= 2) begin
        s = (j-2)/H;
        if (s > ns-1) s = ns-1;
        e = m_exp(cmd, n, s, tx);
      end else e = {pscl, psda};
      chk({tag, " scl"}, 32'(scl_oe), 32'(e[1]));
      chk({tag, " sda"}, 32'(sda_oe), 32'(e[0]));
      s = (j < 2) ? 0 : (j-2)/H;
      slave_low = s_exp(cmd, n, s, ap, rx);
      if (poke && j == 5) begin wr_en = 1'b1; wr_addr = 8'h50; wr_data = 32'hFFFF_FFFF; end
      if (poke && j == 6) wr_en = 1'b0;
    end
    slave_low = 1'b0;
    pscl = e[1]; psda = e[0];
    if (cmd == 4 || cmd == 5)
      for (int i = 0; i < n; i++) cur_dat[i*8 +: 8] = rx[i*8 +: 8];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    rd(8'h44, rv); chk("R1 cmd word", rv, 32'h0);
    rd(8'h40, rv); chk("R1 cfg word", rv, 32'h0063_000C);
    chk("R1 pads", {scl_oe, sda_oe}, 2'b00);

    wr(8'h40, 32'h0003_0002);
    rd(8'h40, rv); chk("R11 cfg readback", rv, 32'h0003_000E);

    run_phase(1, 1, 8'h0, 64'h0, 0);
    wr(8'h50, 32'h5AC3_0F81); wr(8'h54, 32'h1234_9E67);
    cur_dat = 64'h1234_9E67_5AC3_0F81;
    run_phase(2, 3, 8'b0000_0101, 64'h0, 0);
    rd(8'h44, rv); chk("R6 ack map 3 bytes", 32'(rv[23:16]), 32'h05);
    run_phase(2, 8, 8'hFF, 64'h0, 0);
    rd(8'h44, rv); chk("R6 ack map 8 bytes", 32'(rv[23:16]), 32'hFF);
    run_phase(2, 5, 8'b0001_0110, 64'h0, 0);
    rd(8'h44, rv); chk("R6 ack map partial", 32'(rv[23:16]), 32'h16);

    run_phase(5, 5, 8'h0, 64'h0000_00A1_B2C3_D4E5, 0);
    rd(8'h50, rv); chk("R7 read word0", rv, cur_dat[31:0]);
    rd(8'h54, rv); chk("R7 read word1", rv, cur_dat[63:32]);
    run_phase(4, 2, 8'h0, 64'h0000_0000_0000_7E3C, 0);
    rd(8'h50, rv); chk("R7 read_last word0", rv, cur_dat[31:0]);
    rd(8'h54, rv); chk("R7 read_last word1", rv, cur_dat[63:32]);

    run_phase(2, 1, 8'h1, 64'h0, 1);
    rd(8'h50, rv); chk("R9 data held during phase", rv, cur_dat[31:0]);
    run_phase(3, 1, 8'h0, 64'h0, 0);

    wr(8'h44, 32'h0000_0061);
    rd(8'h44, rv); chk("R8 unknown code no trigger", 32'(rv[0]), 32'h0);
    repeat (20) @(negedge clk);
    #1 chk("R8 pads still", {scl_oe, sda_oe}, 2'b00);

    wr(8'h40, 32'h0003_0000);
    rd(8'h40, rv); chk("R11 cfg disabled", rv, 32'h0003_000C);
    wr(8'h44, 32'h0000_0011);
    rd(8'h44, rv); chk("R8 disabled no trigger", 32'(rv[0]), 32'h0);
    repeat (10) @(negedge clk);
    #1 chk("R8 disabled pads", {scl_oe, sda_oe}, 2'b00);

    wr(8'h40, 32'h8003_0002);
    #1 chk("R12 push-pull idle", {scl_oe, scl_o, sda_oe, sda_o}, 4'b1111);

    wr(8'h40, 32'h0003_0003);
    stretch_low = 1'b1;
    wr(8'h44, 32'h0000_0021);
    repeat (100) @(negedge clk);
    #1 rd(8'h44, rv); chk("R10 held by slave", 32'(rv[0]), 32'h1);
    chk("R10 scl released", 32'(scl_oe), 32'h0);
    stretch_low = 1'b0;
    for (int c = 0; c < 600 && rd_data[0]; c++) begin @(negedge clk); #1; end
    rd(8'h44, rv); chk("R10 finishes", 32'(rv[0]), 32'h0);
    chk("R10 no ack seen", 32'(rv[23:16]), 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule